// File: doc/BRIEF.md
# SDRAM Command Decoder with Mode Register

This block is the device-side command front end of a four-bank, x16 synchronous DRAM. On every rising clock edge it samples the chip select, the three command strobes, the clock enable, the bank bits and the 12-bit multiplexed address. From these it works out the command and checks it against the bank state it keeps. It records which row is open in each bank, holds the programmed mode word, and tracks the two clock-enable states. With a bank open, a low clock enable suspends the clock and freezes a running burst. With every bank idle, it enters power down.

The outputs give the accepted command and the bank, row and column latched with it. They also give the open-row table, the decoded mode fields and the status flags: mode write in progress, unconfigured, reserved bits set, protocol error, suspended and powered down. A command that breaks the bank or mode rules is reported as a NOP and sets a sticky protocol-error flag. The memory array, the data path, refresh and analog timing are handled elsewhere.

Top module: `sdram_cmd_front`

## Requirements
- R1: With cs_n high the strobes and address are ignored. On the following edge cmd_o shows DESEL (code 0) and no bank or mode state changes.
- R2: With cs_n low, {ras_n,cas_n,we_n} decodes as follows: 000 mode set (code 2), 011 activate (3), 101 read (4), 100 write (5), 010 precharge (6, or 7 when addr[10] is high). Every other pattern is NOP (1). cmd_o shows the accepted command one edge after sampling.
- R3: An accepted mode set stores {ba,addr}. mrs_busy is high for exactly one cycle after it. On the next running edge the stored word becomes visible: burst_len = addr[2:0], burst_il = addr[3], cas_lat = addr[6:4], wr_single = addr[9]. unconfigured is high from reset until that moment.
- R4: A mode set is rejected while any bank is open or while mrs_busy is high. It then shows as NOP, sets proto_err and leaves the mode fields unchanged.
- R5: mode_err is high while the visible mode word has any of addr[8:7], addr[11:10] or ba[1:0] nonzero.
- R6: Activate opens the bank and latches cmd_bank and cmd_row = addr. Read and write latch cmd_bank and cmd_col = addr[8:0]. Precharge closes the bank and latches cmd_bank.
- R7: Precharge with addr[10] high closes every bank.
- R8: An activate to an open bank, or a read or write to a closed bank, is treated as NOP and sets proto_err. proto_err stays set until reset.
- R9: If cke is sampled low while a bank is open, suspended rises on the next edge. While it is high and cke stays low, every output holds its value and all inputs are ignored.
- R10: If cke is sampled low while all banks are idle, power_down rises on the next edge. The first edge with cke high clears it, and the command sampled on that edge is accepted.
- R11: Reset clears all state: cmd_o DESEL, no bank open, all flags low except unconfigured.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge |
| rst_n | input | 1 | Asynchronous reset, active low |
| cke | input | 1 | Clock enable |
| cs_n | input | 1 | Chip select, active low |
| ras_n | input | 1 | Row strobe, active low |
| cas_n | input | 1 | Column strobe, active low |
| we_n | input | 1 | Write enable, active low |
| ba | input | 2 | Bank address |
| addr | input | 12 | Multiplexed row/column/mode address |
| cmd_o | output | 3 | Accepted command code |
| cmd_bank | output | 2 | Bank latched with the last bank command |
| cmd_row | output | 12 | Row latched by the last activate |
| cmd_col | output | 9 | Column latched by the last read or write |
| bank_open | output | 4 | One bit per bank, high when a row is open |
| open_rows | output | 48 | Open row per bank, bank 0 in the low 12 bits |
| burst_len | output | 3 | Burst length code |
| burst_il | output | 1 | Burst type, high for interleaved |
| cas_lat | output | 3 | CAS latency code |
| wr_single | output | 1 | Write burst mode bit |
| mode_err | output | 1 | Reserved mode bits nonzero |
| unconfigured | output | 1 | No mode word programmed since reset |
| mrs_busy | output | 1 | Mode write in its second cycle |
| proto_err | output | 1 | Sticky protocol error |
| suspended | output | 1 | Clock suspend active |
| power_down | output | 1 | Power down active |

## Verification
The bench goes after the edges where two rules meet. One is a mode set issued in the busy cycle of an earlier one; a design that ignored the busy window would overwrite the word and never flag it. Another is a write on the very edge that wakes a suspend; a design that needed an extra cycle to wake would drop it. The bench also sends commands while cke is low in both suspend and power down, and a design that only gated the command decoder would still change bank state. Duplicate activates and reads to closed banks check that a bad command leaves both the row table and the latched address untouched.

// File: rtl/sdram_cmd_pkg.sv
package sdram_cmd_pkg;
   typedef enum logic [2:0] {
      CMD_DESEL = 3'd0,
      CMD_NOP   = 3'd1,
      CMD_MRS   = 3'd2,
      CMD_ACT   = 3'd3,
      CMD_RD    = 3'd4,
      CMD_WR    = 3'd5,
      CMD_PRE   = 3'd6,
      CMD_PREA  = 3'd7
   } cmd_e;
endpackage

// File: rtl/sdram_cmd_decode.sv
module sdram_cmd_decode
   import sdram_cmd_pkg::*;
(
   input  logic cs_n,
   input  logic ras_n,
   input  logic cas_n,
   input  logic we_n,
   input  logic all_bit,
   output cmd_e raw
);
   always_comb begin
      if (cs_n) begin
         raw = CMD_DESEL;
      end else begin
         unique case ({ras_n, cas_n, we_n})
            3'b000:  raw = CMD_MRS;
            3'b011:  raw = CMD_ACT;
            3'b101:  raw = CMD_RD;
            3'b100:  raw = CMD_WR;
            3'b010:  raw = all_bit ? CMD_PREA : CMD_PRE;
            default: raw = CMD_NOP;
         endcase
      end
   end
endmodule

// File: rtl/sdram_cke_gate.sv
module sdram_cke_gate (
   input  logic clk,
   input  logic rst_n,
   input  logic cke,
   input  logic any_open,
   output logic run,
   output logic suspended,
   output logic power_down
);
   assign run = !(suspended || power_down) || cke;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         suspended  <= 1'b0;
         power_down <= 1'b0;
      end else if (run) begin
         suspended  <= !cke && any_open;
         power_down <= !cke && !any_open;
      end
   end
endmodule

// File: rtl/sdram_bank_table.sv
module sdram_bank_table
   import sdram_cmd_pkg::*;
#(
   parameter int NB    = 4,
   parameter int ROW_W = 12,
   localparam int BA_W = (NB > 1) ? $clog2(NB) : 1
) (
   input  logic                clk,
   input  logic                rst_n,
   input  logic                run,
   input  cmd_e                cmd,
   input  logic [BA_W-1:0]     ba,
   input  logic [ROW_W-1:0]    row,
   output logic [NB-1:0]       open_q,
   output logic [NB*ROW_W-1:0] rows_q
);
   for (genvar g = 0; g < NB; g++) begin : g_bank
      logic hit;
      assign hit = (ba == BA_W'(g));

      always_ff @(posedge clk or negedge rst_n) begin
         if (!rst_n) begin
            open_q[g]                    <= 1'b0;
            rows_q[g*ROW_W +: ROW_W]     <= '0;
         end else if (run) begin
            if (cmd == CMD_ACT && hit) begin
               open_q[g]                 <= 1'b1;
               rows_q[g*ROW_W +: ROW_W]  <= row;
            end else if (cmd == CMD_PREA || (cmd == CMD_PRE && hit)) begin
               open_q[g]                 <= 1'b0;
            end
         end
      end
   end
endmodule

// File: rtl/sdram_mode_reg.sv
module sdram_mode_reg #(
   parameter int ADDR_W = 12,
   parameter int BA_W   = 2,
   parameter int BL_LO  = 0,
   parameter int BT_BIT = 3,
   parameter int CL_LO  = 4,
   parameter int WB_BIT = 9,
   localparam int MW    = ADDR_W + BA_W
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              run,
   input  logic              load,
   input  logic [BA_W-1:0]   ba,
   input  logic [ADDR_W-1:0] addr,
   output logic              busy,
   output logic              unconfigured,
   output logic [2:0]        burst_len,
   output logic              burst_il,
   output logic [2:0]        cas_lat,
   output logic              wr_single,
   output logic              mode_err
);
   localparam logic [MW-1:0] USED = (MW'(7) << BL_LO) | (MW'(1) << BT_BIT) |
                                    (MW'(7) << CL_LO) | (MW'(1) << WB_BIT);

   if (BL_LO + 3 > ADDR_W || CL_LO + 3 > ADDR_W) begin : g_bad_field
      $error("mode field exceeds address width");
   end
   if (BT_BIT >= ADDR_W || WB_BIT >= ADDR_W) begin : g_bad_bit
      $error("mode bit exceeds address width");
   end

   logic [MW-1:0] shadow_q, live_q;
   logic          cfg_q;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         shadow_q <= '0;
         live_q   <= '0;
         busy     <= 1'b0;
         cfg_q    <= 1'b0;
      end else if (run) begin
         if (busy) begin
            live_q <= shadow_q;
            cfg_q  <= 1'b1;
         end
         busy <= load;
         if (load) shadow_q <= {ba, addr};
      end
   end

   assign unconfigured = !cfg_q;
   assign burst_len    = live_q[BL_LO +: 3];
   assign burst_il     = live_q[BT_BIT];
   assign cas_lat      = live_q[CL_LO +: 3];
   assign wr_single    = live_q[WB_BIT];
   assign mode_err     = |(live_q & ~USED);
endmodule

// File: rtl/sdram_cmd_front.sv
module sdram_cmd_front
   import sdram_cmd_pkg::*;
#(
   parameter int NUM_BANKS = 4,
   parameter int ADDR_W    = 12,
   parameter int COL_W     = 9,
   parameter int AP_BIT    = 10,
   localparam int BA_W     = (NUM_BANKS > 1) ? $clog2(NUM_BANKS) : 1,
   localparam int ROW_W    = ADDR_W
) (
   input  logic                    clk,
   input  logic                    rst_n,
   input  logic                    cke,
   input  logic                    cs_n,
   input  logic                    ras_n,
   input  logic                    cas_n,
   input  logic                    we_n,
   input  logic [BA_W-1:0]         ba,
   input  logic [ADDR_W-1:0]       addr,
   output logic [2:0]              cmd_o,
   output logic [BA_W-1:0]         cmd_bank,
   output logic [ROW_W-1:0]        cmd_row,
   output logic [COL_W-1:0]        cmd_col,
   output logic [NUM_BANKS-1:0]    bank_open,
   output logic [NUM_BANKS*ROW_W-1:0] open_rows,
   output logic [2:0]              burst_len,
   output logic                    burst_il,
   output logic [2:0]              cas_lat,
   output logic                    wr_single,
   output logic                    mode_err,
   output logic                    unconfigured,
   output logic                    mrs_busy,
   output logic                    proto_err,
   output logic                    suspended,
   output logic                    power_down
);
   if (NUM_BANKS != (1 << BA_W)) begin : g_bad_banks
      $error("NUM_BANKS must be a power of two");
   end
   if (COL_W > ADDR_W || AP_BIT >= ADDR_W) begin : g_bad_addr
      $error("column width or precharge-all bit outside address");
   end

   cmd_e raw, eff, cmd_q;
   logic run, any_open, bank_hit, bad;

   sdram_cmd_decode u_dec (
      .cs_n(cs_n), .ras_n(ras_n), .cas_n(cas_n), .we_n(we_n),
      .all_bit(addr[AP_BIT]), .raw(raw)
   );

   sdram_cke_gate u_cke (
      .clk(clk), .rst_n(rst_n), .cke(cke), .any_open(any_open),
      .run(run), .suspended(suspended), .power_down(power_down)
   );

   assign any_open = |bank_open;
   assign bank_hit = bank_open[ba];

   always_comb begin
      bad = 1'b0;
      unique case (raw)
         CMD_MRS:          bad = mrs_busy || any_open;
         CMD_ACT:          bad = mrs_busy || bank_hit;
         CMD_RD, CMD_WR:   bad = mrs_busy || !bank_hit;
         CMD_PRE, CMD_PREA: bad = mrs_busy;
         default:          bad = 1'b0;
      endcase
      eff = bad ? CMD_NOP : raw;
   end

   sdram_bank_table #(.NB(NUM_BANKS), .ROW_W(ROW_W)) u_banks (
      .clk(clk), .rst_n(rst_n), .run(run), .cmd(eff), .ba(ba),
      .row(addr), .open_q(bank_open), .rows_q(open_rows)
   );

   sdram_mode_reg #(.ADDR_W(ADDR_W), .BA_W(BA_W)) u_mode (
      .clk(clk), .rst_n(rst_n), .run(run), .load(eff == CMD_MRS),
      .ba(ba), .addr(addr), .busy(mrs_busy), .unconfigured(unconfigured),
      .burst_len(burst_len), .burst_il(burst_il), .cas_lat(cas_lat),
      .wr_single(wr_single), .mode_err(mode_err)
   );

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         cmd_q     <= CMD_DESEL;
         cmd_bank  <= '0;
         cmd_row   <= '0;
         cmd_col   <= '0;
         proto_err <= 1'b0;
      end else if (run) begin
         cmd_q <= eff;
         if (bad) proto_err <= 1'b1;
         unique case (eff)
            CMD_ACT: begin
               cmd_bank <= ba;
               cmd_row  <= addr;
            end
            CMD_RD, CMD_WR: begin
               cmd_bank <= ba;
               cmd_col  <= addr[COL_W-1:0];
            end
            CMD_PRE: cmd_bank <= ba;
            default: ;
         endcase
      end
   end

   assign cmd_o = cmd_q;
endmodule

// File: rtl/sdram_cmd_front_chk.sv
module sdram_cmd_front_chk #(
   parameter int NB    = 4,
   parameter int ROW_W = 12,
   parameter int COL_W = 9
) (
   input logic             clk,
   input logic             rst_n,
   input logic             cke,
   input logic             cs_n,
   input logic [2:0]       cmd_o,
   input logic [NB-1:0]    bank_open,
   input logic [ROW_W-1:0] cmd_row,
   input logic [COL_W-1:0] cmd_col,
   input logic             proto_err,
   input logic             mrs_busy,
   input logic             unconfigured,
   input logic             suspended,
   input logic             power_down
);
   logic frozen;
   assign frozen = suspended || power_down;

   // R1
   desel_ignored_chk: assert property (@(posedge clk) disable iff (!rst_n)
      ((!frozen || cke) && cs_n) |=> (cmd_o == 3'd0 && $stable(bank_open)));

   // R3
   busy_single_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (mrs_busy && cke) |=> !mrs_busy);

   // R3
   configured_chk: assert property (@(posedge clk) disable iff (!rst_n)
      $fell(mrs_busy) |-> !unconfigured);

   // R8
   perr_sticky_chk: assert property (@(posedge clk) disable iff (!rst_n)
      proto_err |=> proto_err);

   // R9
   suspend_entry_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (!frozen && !cke && (|bank_open)) |=> (suspended && !power_down));

   // R9
   freeze_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (frozen && !cke) |=> ($stable(cmd_o) && $stable(bank_open) &&
                            $stable(cmd_row) && $stable(cmd_col) &&
                            $stable(proto_err)));

   // R10
   pd_entry_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (!frozen && !cke && !(|bank_open)) |=> (power_down && !suspended));

   // R10
   wake_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (frozen && cke) |=> !frozen);

   // R11
   state_mutex_chk: assert property (@(posedge clk) disable iff (!rst_n)
      !(suspended && power_down));
endmodule

bind sdram_cmd_front sdram_cmd_front_chk #(
   .NB(NUM_BANKS), .ROW_W(ROW_W), .COL_W(COL_W)
) u_chk (
   .clk(clk), .rst_n(rst_n), .cke(cke), .cs_n(cs_n), .cmd_o(cmd_o),
   .bank_open(bank_open), .cmd_row(cmd_row), .cmd_col(cmd_col),
   .proto_err(proto_err), .mrs_busy(mrs_busy), .unconfigured(unconfigured),
   .suspended(suspended), .power_down(power_down)
);

// File: tb/tb_sdram_cmd_front.sv
module tb_sdram_cmd_front;
   logic clk = 1'b0;
   logic rst_n = 1'b0;
   logic cke = 1'b1, cs_n = 1'b0, ras_n = 1'b1, cas_n = 1'b1, we_n = 1'b1;
   logic [1:0]  ba = '0;
   logic [11:0] addr = '0;

   logic [2:0]  cmd_o;
   logic [1:0]  cmd_bank;
   logic [11:0] cmd_row;
   logic [8:0]  cmd_col;
   logic [3:0]  bank_open;
   logic [47:0] open_rows;
   logic [2:0]  burst_len, cas_lat;
   logic        burst_il, wr_single, mode_err, unconfigured, mrs_busy;
   logic        proto_err, suspended, power_down;

   always #5 clk = ~clk;

   sdram_cmd_front dut (
      .clk(clk), .rst_n(rst_n), .cke(cke), .cs_n(cs_n), .ras_n(ras_n),
      .cas_n(cas_n), .we_n(we_n), .ba(ba), .addr(addr), .cmd_o(cmd_o),
      .cmd_bank(cmd_bank), .cmd_row(cmd_row), .cmd_col(cmd_col),
      .bank_open(bank_open), .open_rows(open_rows), .burst_len(burst_len),
      .burst_il(burst_il), .cas_lat(cas_lat), .wr_single(wr_single),
      .mode_err(mode_err), .unconfigured(unconfigured), .mrs_busy(mrs_busy),
      .proto_err(proto_err), .suspended(suspended), .power_down(power_down)
   );

   int checks = 0, errors = 0;
   bit done = 1'b0;

   // behavioural reference state
   int          m_cmd;
   logic [3:0]  m_open;
   logic [11:0] m_rows [4];
   logic [1:0]  m_bank;
   logic [11:0] m_row;
   logic [8:0]  m_col;
   logic [13:0] m_shadow, m_live;
   bit          m_busy, m_cfg, m_perr, m_susp, m_pd, m_valid;

   task automatic chk(input string tag, input logic [63:0] act, input logic [63:0] exp);
      checks++;
      if (act !== exp) begin
         errors++;
         $display("FAIL %s actual=%0h expected=%0h", tag, act, exp);
      end
   endtask

   task automatic model_reset();
      m_cmd = 0; m_open = '0; m_bank = '0; m_row = '0; m_col = '0;
      m_shadow = '0; m_live = '0; m_busy = 0; m_cfg = 0; m_perr = 0;
      m_susp = 0; m_pd = 0; m_valid = 0;
      foreach (m_rows[i]) m_rows[i] = '0;
   endtask

   task automatic model_step();
      int raw, eff;
      bit any, hit, bad;
      m_valid = 1;
      if ((m_susp || m_pd) && !cke) return;
      any = |m_open;
      hit = m_open[ba];
      if (cs_n) raw = 0;
      else case ({ras_n, cas_n, we_n})
         3'b000:  raw = 2;
         3'b011:  raw = 3;
         3'b101:  raw = 4;
         3'b100:  raw = 5;
         3'b010:  raw = addr[10] ? 7 : 6;
         default: raw = 1;
      endcase
      case (raw)
         2:       bad = m_busy || any;
         3:       bad = m_busy || hit;
         4, 5:    bad = m_busy || !hit;
         6, 7:    bad = m_busy;
         default: bad = 0;
      endcase
      eff = bad ? 1 : raw;
      if (bad) m_perr = 1;
      if (m_busy) begin m_live = m_shadow; m_cfg = 1; m_busy = 0; end
      case (eff)
         2: begin m_shadow = {ba, addr}; m_busy = 1; end
         3: begin m_open[ba] = 1; m_rows[ba] = addr; m_bank = ba; m_row = addr; end
         4, 5: begin m_bank = ba; m_col = addr[8:0]; end
         6: begin m_open[ba] = 0; m_bank = ba; end
         7: m_open = '0;
         default: ;
      endcase
      m_cmd  = eff;
      m_susp = !cke && any;
      m_pd   = !cke && !any;
   endtask

   always @(posedge clk) begin
      if (!rst_n) model_reset();
      else model_step();
   end

   // per-cycle comparison against the reference
   always @(negedge clk) begin
      if (rst_n && m_valid && !done) begin
         chk("R2 cmd_o", cmd_o, m_cmd);
         chk("R6 cmd_bank", cmd_bank, m_bank);
         chk("R6 cmd_row", cmd_row, m_row);
         chk("R6 cmd_col", cmd_col, m_col);
         chk("R7 bank_open", bank_open, m_open);
         chk("R6 open_rows", open_rows, {m_rows[3], m_rows[2], m_rows[1], m_rows[0]});
         chk("R3 mode fields", {burst_len, burst_il, cas_lat, wr_single},
             {m_live[2:0], m_live[3], m_live[6:4], m_live[9]});
         chk("R3 busy/unconfigured", {mrs_busy, unconfigured}, {m_busy, !m_cfg});
         chk("R5 mode_err", mode_err, |(m_live & 14'h3D80));
         chk("R8 proto_err", proto_err, m_perr);
         chk("R9 suspended", suspended, m_susp);
         chk("R10 power_down", power_down, m_pd);
      end
   end

   task automatic drive(input logic c, r, a, w, input logic [1:0] b,
                        input logic [11:0] ad, input logic k);
      @(negedge clk);
      cs_n = c; ras_n = r; cas_n = a; we_n = w; ba = b; addr = ad; cke = k;
   endtask
   task automatic settle(); @(posedge clk); #2; endtask
   task automatic nop(input logic k);  drive(0, 1, 1, 1, 2'd0, 12'h000, k); endtask
   task automatic act(input logic [1:0] b, input logic [11:0] r, input logic k);
      drive(0, 0, 1, 1, b, r, k);
   endtask
   task automatic mrs(input logic [1:0] b, input logic [11:0] v); drive(0, 0, 0, 0, b, v, 1); endtask

   initial begin
      repeat (20000) @(posedge clk);
      if (!done) begin
         done = 1;
         checks++; errors++;
         $display("FAIL watchdog expired actual=running expected=finished");
         $display("Result: errors=%0d of %0d checks", errors, checks);
         $finish;
      end
   end

   initial begin
      repeat (3) @(posedge clk);
      #2;
      // R11 reset state
      chk("R11 reset cmd", cmd_o, 3'd0);
      chk("R11 reset banks", bank_open, 4'h0);
      chk("R11 reset flags", {unconfigured, mrs_busy, proto_err, suspended, power_down}, 5'b10000);
      @(negedge clk); rst_n = 1'b1;

      // R1 deselect with all strobes low
      drive(1, 0, 0, 0, 2'd3, 12'hFFF, 1); settle();
      chk("R1 deselect cmd", cmd_o, 3'd0);
      chk("R1 deselect no mode write", {mrs_busy, unconfigured}, 2'b01);

      // R3 two-cycle mode write
      mrs(2'd0, 12'h22B); settle();
      chk("R3 busy after set", {mrs_busy, unconfigured}, 2'b11);
      nop(1); settle();
      chk("R3 published", {mrs_busy, unconfigured}, 2'b00);
      chk("R3 fields", {burst_len, burst_il, cas_lat, wr_single}, {3'd3, 1'b1, 3'd2, 1'b1});
      chk("R5 clean word", mode_err, 1'b0);

      // R6 activate
      act(2'd2, 12'hABC, 1); settle();
      chk("R6 activate", {cmd_o, cmd_bank, cmd_row, bank_open}, {3'd3, 2'd2, 12'hABC, 4'b0100});
      // R8 activate open bank
      act(2'd2, 12'h123, 1); settle();
      chk("R8 double activate", {cmd_o, cmd_row, proto_err}, {3'd1, 12'hABC, 1'b1});
      // R4 mode set with open bank
      mrs(2'd0, 12'h031); settle();
      chk("R4 rejected cmd", {cmd_o, mrs_busy}, {3'd1, 1'b0});
      nop(1); settle();
      chk("R4 mode kept", {burst_len, cas_lat}, {3'd3, 3'd2});

      // R6 read latches column
      drive(0, 1, 0, 1, 2'd2, 12'hDF5, 1); settle();
      chk("R6 read column", {cmd_o, cmd_col}, {3'd4, 9'h1F5});
      // R8 write to closed bank
      drive(0, 1, 0, 0, 2'd0, 12'h011, 1); settle();
      chk("R8 write closed", {cmd_o, cmd_col}, {3'd1, 9'h1F5});

      // R9 clock suspend
      nop(0); settle();
      chk("R9 suspend entry", {suspended, power_down}, 2'b10);
      act(2'd1, 12'h777, 0); settle();
      drive(0, 0, 1, 0, 2'd0, 12'h400, 0); settle();
      chk("R9 frozen", {cmd_o, bank_open, cmd_row}, {3'd1, 4'b0100, 12'hABC});
      drive(0, 1, 0, 0, 2'd2, 12'h00A, 1); settle();
      chk("R9 wake with write", {suspended, cmd_o, cmd_col}, {1'b0, 3'd5, 9'h00A});

      // R7 precharge all
      drive(0, 0, 1, 0, 2'd1, 12'h400, 1); settle();
      chk("R7 precharge all", {cmd_o, bank_open}, {3'd7, 4'h0});

      // R10 power down
      nop(0); settle();
      chk("R10 pd entry", {power_down, suspended}, 2'b10);
      act(2'd3, 12'h333, 0); settle();
      act(2'd3, 12'h334, 0); settle();
      chk("R10 ignored", {bank_open, cmd_o}, {4'h0, 3'd1});
      act(2'd1, 12'h555, 1); settle();
      chk("R10 wake accepts", {power_down, bank_open, cmd_row}, {1'b0, 4'b0010, 12'h555});
      drive(0, 0, 1, 0, 2'd1, 12'h000, 1); settle();
      chk("R6 precharge bank", {cmd_o, cmd_bank, bank_open}, {3'd6, 2'd1, 4'h0});

      // R5 reserved bits, R4 set during busy
      mrs(2'd1, 12'h032); settle();
      chk("R4 first set busy", mrs_busy, 1'b1);
      mrs(2'd0, 12'h022); settle();
      chk("R4 set during busy", {cmd_o, mrs_busy}, {3'd1, 1'b0});
      chk("R5 reserved flagged", {mode_err, burst_len, cas_lat}, {1'b1, 3'd2, 3'd3});

      // mixed traffic compared every cycle
      for (int i = 0; i < 600; i++) begin
         logic [2:0] s;
         s = 3'($urandom_range(0, 7));
         drive(($urandom_range(0, 9) == 0), s[2], s[1], s[0],
               2'($urandom_range(0, 3)), 12'($urandom),
               ($urandom_range(0, 7) != 0));
      end
      nop(1); settle(); settle();
      done = 1;
      $display("Result: errors=%0d of %0d checks", errors, checks);
      $finish;
   end
endmodule